// File: doc/BRIEF.md
# Multi-Client Mailbox Request Arbiter

This block sits between a set of client mailboxes and a single memory transfer engine. Each client owns a pair of 32-bit mailbox words. The first word holds the request: a pending flag, a direction bit, a service field, a bank number and an address. The second word holds an argument, such as a count or a data value. The arbiter picks one pending client at a time. It decodes the top byte of that client's request into a command for the engine, and it attaches the client's burst limit. The top byte is handled as one dispatch code, so a single compare separates ordinary memory traffic, control traffic for the reserved bank and the start of a request list.

When the engine reports an outcome, the arbiter does one of three things:
- On success, it writes a cleared first word back to the mailbox.
- On error, it writes a nonzero first word back and places the engine's result in the second word.
- On a yield partway through a transfer, it leaves the request pending and arbitrates again. A client marked locked keeps the engine through such a yield, and its bursts are never limited.

Selection works in two steps. The highest priority level wins first. Among clients at the winning level, a rotating pointer gives the first turn to the client after the one served last.

The mailbox storage outside the block applies a write-back on the clock edge that ends the write-back cycle.

Top module: `mbx_arbiter`

## Requirements
- R1: After reset no command is issued and no write-back occurs while no mailbox holds a pending request, and the rotating pointer starts so that client 0 is first in line.
- R2: A client is a candidate only when bit 31 of its first word is set and its enable input is high. A pending request from a disabled client is never dispatched, and its mailbox words stay unchanged.
- R3: When the engine returns status 0 (or the unused code 3), the arbiter issues one write-back with first word 32'h0, which clears bit 31, and it does not rewrite the second word.
- R4: When the engine returns status 1, the write-back sets the first word to 32'h1 and the second word to the engine's result.
- R5: Except for the codes covered by R6 and R7, bit 30 of the request selects the command kind: 1 gives kind 0 (read) and 0 gives kind 1 (write). The command also carries the service field from bits 29:28, the bank from bits 27:24, the address from bits 23:0, and the second mailbox word as its argument.
- R6: A request whose bank field (bits 27:24) is 15 and whose top byte is not 8'hBF is dispatched as kind 2 (control), whatever the value of bit 30.
- R7: A top byte of 8'hBF is dispatched as kind 3 (list start). The command address is bits 19:0 of the word, zero-extended, so bits 23:20 are dropped.
- R8: An unlocked client's command carries that client's configured burst limit.
- R9: When several clients are pending, a client with a higher priority value (0 to 7) is always served before a client with a lower one.
- R10: Among pending clients of equal priority, the first one served is the client whose index follows the last served client, searching upward and wrapping from the highest index to 0.
- R11: A locked client's command carries an all-ones burst limit. When the engine returns status 2 (yield) for a locked client, that same client is dispatched again on the next cycle, even if other clients are pending.
- R12: When the engine returns status 2 for an unlocked client, no write-back occurs and the request stays pending. The next dispatch goes to the next client in rotation, and the yielded client is served again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbx_word0 | input | NCLIENT x 32 | First mailbox word of each client (request) |
| mbx_word1 | input | NCLIENT x 32 | Second mailbox word of each client (argument) |
| cfg_en | input | NCLIENT | Client takes part in arbitration |
| cfg_lock | input | NCLIENT | Client keeps the engine across yields, unlimited burst |
| cfg_prio | input | NCLIENT x 3 | Client priority, 7 highest |
| cfg_burst | input | NCLIENT x BURST_W | Client burst limit |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_client | output | clog2(NCLIENT) | Client being served |
| cmd_kind | output | 2 | 0 read, 1 write, 2 control, 3 list start |
| cmd_service | output | 2 | Service field of the request |
| cmd_bank | output | 4 | Bank field of the request |
| cmd_addr | output | 24 | Memory address or list pointer |
| cmd_arg | output | 32 | Second mailbox word |
| cmd_burst | output | BURST_W | Burst limit for this command |
| eng_done | input | 1 | Engine outcome strobe |
| eng_status | input | 2 | 0 ok, 1 error, 2 yield |
| eng_result | input | 32 | Engine result or error value |
| wb_valid | output | 1 | Mailbox write-back strobe |
| wb_client | output | clog2(NCLIENT) | Mailbox being written back |
| wb_word0 | output | 32 | New first word |
| wb_word1 | output | 32 | New second word |
| wb_word1_en | output | 1 | Second word is written |

## Verification
The bench builds the block with its default parameters: eight clients, which gives 3-bit client numbers, and 16-bit burst limits. With eight clients, the rotating pointer can be driven across its wrap from client 7 back to a low index. The single-request table covers every command kind and both completion outcomes at chosen client indices. Separate sequences then set up competing clients to exercise priority ordering, rotation order, and yields from locked and unlocked clients.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 24;
    localparam int LIST_W = 20;
    localparam int PRIO_W = 3;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] LIST_CODE = 8'hBF;
    localparam logic [3:0]        CTRL_BANK = 4'hF;
    localparam logic [WORD_W-1:0] ERR_MARK  = 32'h1;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_CTRL  = 2'd2,
        K_LIST  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        E_OK    = 2'd0,
        E_ERR   = 2'd1,
        E_YIELD = 2'd2
    } eng_st_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } arb_st_e;

    typedef struct packed {
        kind_e             kind;
        logic [1:0]        service;
        logic [3:0]        bank;
        logic [ADDR_W-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    always_comb begin
        cmd.service = word[29:28];
        cmd.bank    = word[27:24];
        cmd.addr    = word[ADDR_W-1:0];
        if (word[WORD_W-1 -: CODE_W] == LIST_CODE) begin
            cmd.kind = K_LIST;
            cmd.addr = ADDR_W'(word[LIST_W-1:0]);
        end else if (word[27:24] == CTRL_BANK) begin
            cmd.kind = K_CTRL;
        end else if (word[30]) begin
            cmd.kind = K_READ;
        end else begin
            cmd.kind = K_WRITE;
        end
    end
endmodule

// File: rtl/mbx_pick.sv
module mbx_pick
    import mbx_pkg::*;
#(
    parameter  int NCLIENT = 8,
    localparam int CID_W   = $clog2(NCLIENT)
) (
    input  logic [NCLIENT-1:0]             req,
    input  logic [NCLIENT-1:0][PRIO_W-1:0] prio,
    input  logic [CID_W-1:0]               last,
    output logic                           found,
    output logic [CID_W-1:0]               pick
);
    logic [CID_W-1:0]  idx;
    logic [PRIO_W-1:0] best;

    // Scan in rotation order starting after the last served client;
    // a strictly higher priority replaces the current choice, so ties
    // keep the earliest client in rotation order.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '0;
        idx   = '0;
        for (int i = 1; i <= NCLIENT; i++) begin
            idx = CID_W'((int'(last) + i) % NCLIENT);
            if (req[idx] && (!found || prio[idx] > best)) begin
                found = 1'b1;
                pick  = idx;
                best  = prio[idx];
            end
        end
    end
endmodule

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
    import mbx_pkg::*;
#(
    parameter  int NCLIENT = 8,
    parameter  int BURST_W = 16,
    localparam int CID_W   = $clog2(NCLIENT)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NCLIENT-1:0][WORD_W-1:0]  mbx_word0,
    input  logic [NCLIENT-1:0][WORD_W-1:0]  mbx_word1,
    input  logic [NCLIENT-1:0]              cfg_en,
    input  logic [NCLIENT-1:0]              cfg_lock,
    input  logic [NCLIENT-1:0][PRIO_W-1:0]  cfg_prio,
    input  logic [NCLIENT-1:0][BURST_W-1:0] cfg_burst,
    output logic                            cmd_valid,
    output logic [CID_W-1:0]                cmd_client,
    output logic [1:0]                      cmd_kind,
    output logic [1:0]                      cmd_service,
    output logic [3:0]                      cmd_bank,
    output logic [ADDR_W-1:0]               cmd_addr,
    output logic [WORD_W-1:0]               cmd_arg,
    output logic [BURST_W-1:0]              cmd_burst,
    input  logic                            eng_done,
    input  logic [1:0]                      eng_status,
    input  logic [WORD_W-1:0]               eng_result,
    output logic                            wb_valid,
    output logic [CID_W-1:0]                wb_client,
    output logic [WORD_W-1:0]               wb_word0,
    output logic [WORD_W-1:0]               wb_word1,
    output logic                            wb_word1_en
);
    arb_st_e           state;
    logic [CID_W-1:0]  cur;
    logic [CID_W-1:0]  rr_last;
    logic [NCLIENT-1:0] pend;
    logic              found;
    logic [CID_W-1:0]  pick;
    cmd_t              dec;
    logic [WORD_W-1:0] wb_w0_q;
    logic [WORD_W-1:0] wb_w1_q;
    logic              wb_w1en_q;

    for (genvar i = 0; i < NCLIENT; i++) begin : g_pend
        assign pend[i] = mbx_word0[i][WORD_W-1] & cfg_en[i];
    end

    mbx_pick #(.NCLIENT(NCLIENT)) pick_i (
        .req   (pend),
        .prio  (cfg_prio),
        .last  (rr_last),
        .found (found),
        .pick  (pick)
    );

    mbx_decode dec_i (
        .word (mbx_word0[cur]),
        .cmd  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur       <= '0;
            rr_last   <= CID_W'(NCLIENT - 1);
            wb_w0_q   <= '0;
            wb_w1_q   <= '0;
            wb_w1en_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (found) begin
                        cur     <= pick;
                        rr_last <= pick;
                        state   <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (eng_done) begin
                        case (eng_status)
                            E_YIELD: state <= cfg_lock[cur] ? S_ISSUE : S_IDLE;
                            E_ERR: begin
                                wb_w0_q   <= ERR_MARK;
                                wb_w1_q   <= eng_result;
                                wb_w1en_q <= 1'b1;
                                state     <= S_DONE;
                            end
                            default: begin
                                wb_w0_q   <= '0;
                                wb_w1_q   <= eng_result;
                                wb_w1en_q <= 1'b0;
                                state     <= S_DONE;
                            end
                        endcase
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_valid   = (state == S_ISSUE);
    assign cmd_client  = cur;
    assign cmd_kind    = dec.kind;
    assign cmd_service = dec.service;
    assign cmd_bank    = dec.bank;
    assign cmd_addr    = dec.addr;
    assign cmd_arg     = mbx_word1[cur];
    assign cmd_burst   = cfg_lock[cur] ? '1 : cfg_burst[cur];

    assign wb_valid    = (state == S_DONE);
    assign wb_client   = cur;
    assign wb_word0    = wb_w0_q;
    assign wb_word1    = wb_w1_q;
    assign wb_word1_en = wb_w1en_q;
endmodule

// File: rtl/mbx_arbiter_chk.sv
module mbx_arbiter_chk
    import mbx_pkg::*;
#(
    parameter  int NCLIENT = 8,
    parameter  int BURST_W = 16,
    localparam int CID_W   = $clog2(NCLIENT)
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NCLIENT-1:0]             req_raw,
    input logic [NCLIENT-1:0]             cfg_lock,
    input logic [NCLIENT-1:0][PRIO_W-1:0] cfg_prio,
    input logic                           cmd_valid,
    input logic [CID_W-1:0]               cmd_client,
    input logic [1:0]                     cmd_kind,
    input logic [3:0]                     cmd_bank,
    input logic [ADDR_W-LIST_W-1:0]       addr_hi,
    input logic [BURST_W-1:0]             cmd_burst,
    input logic                           eng_done,
    input logic [1:0]                     eng_status,
    input logic                           wb_valid,
    input logic [WORD_W-1:0]              wb_word0,
    input logic                           wb_word1_en
);
    logic             waiting;
    logic             relock;
    logic [CID_W-1:0] held;
    logic             higher;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
            relock  <= 1'b0;
            held    <= '0;
        end else begin
            if (cmd_valid) begin
                waiting <= 1'b1;
                relock  <= 1'b0;
                held    <= cmd_client;
            end else if (waiting && eng_done) begin
                waiting <= 1'b0;
                relock  <= (eng_status == 2'd2) && cfg_lock[held];
            end
        end
    end

    always_comb begin
        higher = 1'b0;
        for (int i = 0; i < NCLIENT; i++) begin
            if (req_raw[i] && cfg_prio[i] > cfg_prio[cmd_client]) higher = 1'b1;
        end
    end

    p_issue_pending_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> req_raw[cmd_client]);

    p_clear_pending_r3: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !wb_word0[WORD_W-1]);

    p_error_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_word1_en) |-> (wb_word0 != '0));

    p_list_ptr_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3) |-> (addr_hi == '0 && cmd_bank == CTRL_BANK));

    p_prio_order_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !relock) |-> !higher);

    p_lock_burst_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cfg_lock[cmd_client]) |-> (&cmd_burst));

    p_lock_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (waiting && eng_done && eng_status == 2'd2 && cfg_lock[held])
        |=> (cmd_valid && cmd_client == $past(held)));

    p_yield_no_wb_r12: assert property (@(posedge clk) disable iff (rst)
        (waiting && eng_done && eng_status == 2'd2) |=> !wb_valid);
endmodule

bind mbx_arbiter mbx_arbiter_chk #(.NCLIENT(NCLIENT), .BURST_W(BURST_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_raw     (pend),
    .cfg_lock    (cfg_lock),
    .cfg_prio    (cfg_prio),
    .cmd_valid   (cmd_valid),
    .cmd_client  (cmd_client),
    .cmd_kind    (cmd_kind),
    .cmd_bank    (cmd_bank),
    .addr_hi     (cmd_addr[mbx_pkg::ADDR_W-1:mbx_pkg::LIST_W]),
    .cmd_burst   (cmd_burst),
    .eng_done    (eng_done),
    .eng_status  (eng_status),
    .wb_valid    (wb_valid),
    .wb_word0    (wb_word0),
    .wb_word1_en (wb_word1_en)
);

// File: tb/mbx_arbiter_tb_top.sv
module mbx_arbiter_tb_top;
    import mbx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int BW = 16;

    typedef struct packed {
        logic [2:0]  cid;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [1:0]  st;
        logic [31:0] res;
        logic [1:0]  kind;
        logic [1:0]  svc;
        logic [3:0]  bank;
        logic [23:0] addr;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{3'd0, 32'hC312_3456, 32'h1111_0000, 2'd0, 32'h0,         2'd0, 2'd0, 4'h3, 24'h123456},
        '{3'd3, 32'h9A00_00FF, 32'h2222_0000, 2'd1, 32'hDEAD_0001, 2'd1, 2'd1, 4'hA, 24'h0000FF},
        '{3'd5, 32'hBF9A_BCDE, 32'h0000_0000, 2'd0, 32'h0,         2'd3, 2'd3, 4'hF, 24'h0ABCDE},
        '{3'd7, 32'hEF00_0042, 32'h3333_0000, 2'd1, 32'h0000_0077, 2'd2, 2'd2, 4'hF, 24'h000042},
        '{3'd2, 32'hA5FF_FFFF, 32'h4444_0000, 2'd0, 32'h0,         2'd1, 2'd2, 4'h5, 24'hFFFFFF},
        '{3'd6, 32'hF100_0010, 32'h5555_0000, 2'd0, 32'h0,         2'd0, 2'd3, 4'h1, 24'h000010},
        '{3'd1, 32'hFF01_2345, 32'h6666_0000, 2'd0, 32'h0,         2'd2, 2'd3, 4'hF, 24'h012345}
    };

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [N-1:0][31:0]     mb0;
    logic [N-1:0][31:0]     mb1;
    logic [N-1:0]           post_mask = '0;
    logic [N-1:0][31:0]     post_w0 = '0;
    logic [N-1:0][31:0]     post_w1 = '0;
    logic [N-1:0]           cfg_en = '1;
    logic [N-1:0]           cfg_lock = '0;
    logic [N-1:0][2:0]      cfg_prio = '0;
    logic [N-1:0][BW-1:0]   cfg_burst;
    logic                   cmd_valid;
    logic [2:0]             cmd_client;
    logic [1:0]             cmd_kind;
    logic [1:0]             cmd_service;
    logic [3:0]             cmd_bank;
    logic [23:0]            cmd_addr;
    logic [31:0]            cmd_arg;
    logic [BW-1:0]          cmd_burst;
    logic                   eng_done = 1'b0;
    logic [1:0]             eng_status = 2'd0;
    logic [31:0]            eng_result = '0;
    logic                   wb_valid;
    logic [2:0]             wb_client;
    logic [31:0]            wb_word0;
    logic [31:0]            wb_word1;
    logic                   wb_word1_en;

    int n_chk  = 0;
    int n_fail = 0;

    logic [2:0]    g_client;
    logic [1:0]    g_kind;
    logic [1:0]    g_svc;
    logic [3:0]    g_bank;
    logic [23:0]   g_addr;
    logic [31:0]   g_arg;
    logic [BW-1:0] g_burst;
    logic          g_wb;
    logic [31:0]   g_wb0;
    logic          g_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Mailbox storage: applies write-backs and client posts on the clock edge.
    always @(posedge clk) begin
        if (rst) begin
            mb0 <= '0;
            mb1 <= '0;
        end else begin
            if (wb_valid) begin
                mb0[wb_client] <= wb_word0;
                if (wb_word1_en) mb1[wb_client] <= wb_word1;
            end
            for (int i = 0; i < N; i++) begin
                if (post_mask[i]) begin
                    mb0[i] <= post_w0[i];
                    mb1[i] <= post_w1[i];
                end
            end
        end
    end

    mbx_arbiter #(.NCLIENT(N), .BURST_W(BW)) dut_i (
        .clk(clk), .rst(rst),
        .mbx_word0(mb0), .mbx_word1(mb1),
        .cfg_en(cfg_en), .cfg_lock(cfg_lock), .cfg_prio(cfg_prio), .cfg_burst(cfg_burst),
        .cmd_valid(cmd_valid), .cmd_client(cmd_client), .cmd_kind(cmd_kind),
        .cmd_service(cmd_service), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_arg(cmd_arg), .cmd_burst(cmd_burst),
        .eng_done(eng_done), .eng_status(eng_status), .eng_result(eng_result),
        .wb_valid(wb_valid), .wb_client(wb_client), .wb_word0(wb_word0),
        .wb_word1(wb_word1), .wb_word1_en(wb_word1_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic stage(input int cid, input logic [31:0] w0, input logic [31:0] w1);
        post_mask[cid] = 1'b1;
        post_w0[cid]   = w0;
        post_w1[cid]   = w1;
    endtask

    task automatic commit();
        @(negedge clk);
        post_mask = '0;
    endtask

    // Waits for a command, captures it, answers with a status and samples the write-back.
    task automatic serve(input logic [1:0] st, input logic [31:0] res);
        g_seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (cmd_valid) begin
                g_seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk("dispatch seen", {31'b0, g_seen}, 32'h1);
        g_client = cmd_client;
        g_kind   = cmd_kind;
        g_svc    = cmd_service;
        g_bank   = cmd_bank;
        g_addr   = cmd_addr;
        g_arg    = cmd_arg;
        g_burst  = cmd_burst;
        @(negedge clk);
        eng_done   = 1'b1;
        eng_status = st;
        eng_result = res;
        @(negedge clk);
        eng_done = 1'b0;
        g_wb     = wb_valid;
        g_wb0    = wb_word0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        string tg;
        for (int i = 0; i < N; i++) cfg_burst[i] = BW'(16'h0100 + i * 16'h11);
        do_reset();

        // R1: quiet after reset with no pending mailbox
        begin
            logic any;
            any = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (cmd_valid || wb_valid) any = 1'b1;
                @(negedge clk);
            end
            chk("R1 idle after reset", {31'b0, any}, 32'h0);
        end

        // Table of single requests: decode, burst, completion
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            stage(int'(VEC[v].cid), VEC[v].w0, VEC[v].w1);
            commit();
            serve(VEC[v].st, VEC[v].res);
            tg = (VEC[v].kind == 2'd3) ? "R7" : (VEC[v].kind == 2'd2) ? "R6" : "R5";
            chk({tg, " client"},  {29'b0, g_client}, {29'b0, VEC[v].cid});
            chk({tg, " kind"},    {30'b0, g_kind},   {30'b0, VEC[v].kind});
            chk({tg, " service"}, {30'b0, g_svc},    {30'b0, VEC[v].svc});
            chk({tg, " bank"},    {28'b0, g_bank},   {28'b0, VEC[v].bank});
            chk({tg, " addr"},    {8'b0, g_addr},    {8'b0, VEC[v].addr});
            chk({tg, " arg"},     g_arg,             VEC[v].w1);
            chk("R8 burst", {16'b0, g_burst}, 32'h0100 + 32'(VEC[v].cid) * 32'h11);
            chk("R3 wb strobe", {31'b0, g_wb}, 32'h1);
            @(negedge clk);
            if (VEC[v].st == 2'd1) begin
                chk("R4 word0", mb0[VEC[v].cid], 32'h1);
                chk("R4 word1", mb1[VEC[v].cid], VEC[v].res);
            end else begin
                chk("R3 word0", mb0[VEC[v].cid], 32'h0);
                chk("R3 word1 kept", mb1[VEC[v].cid], VEC[v].w1);
            end
        end

        // R2: disabled client is ignored
        do_reset();
        cfg_en[5] = 1'b0;
        stage(5, 32'hC100_0004, 32'h0000_ABCD);
        commit();
        begin
            logic any;
            any = 1'b0;
            for (int k = 0; k < 20; k++) begin
                if (cmd_valid || wb_valid) any = 1'b1;
                @(negedge clk);
            end
            chk("R2 disabled no dispatch", {31'b0, any}, 32'h0);
            chk("R2 disabled word0 kept", mb0[5], 32'hC100_0004);
        end
        cfg_en = '1;

        // R9: priority ordering
        do_reset();
        cfg_prio[1] = 3'd2;
        cfg_prio[4] = 3'd5;
        cfg_prio[6] = 3'd5;
        @(negedge clk);
        stage(1, 32'hC000_0001, 32'h0);
        stage(4, 32'hC000_0004, 32'h0);
        stage(6, 32'hC000_0006, 32'h0);
        commit();
        serve(2'd0, 32'h0);
        chk("R9 first", {29'b0, g_client}, 32'd4);
        serve(2'd0, 32'h0);
        chk("R9 second", {29'b0, g_client}, 32'd6);
        serve(2'd0, 32'h0);
        chk("R9 third", {29'b0, g_client}, 32'd1);
        cfg_prio = '0;

        // R10: rotation among equal priority, including wrap
        do_reset();
        stage(2, 32'hC000_0002, 32'h0);
        stage(5, 32'hC000_0005, 32'h0);
        stage(6, 32'hC000_0006, 32'h0);
        commit();
        serve(2'd0, 32'h0);
        chk("R10 order a", {29'b0, g_client}, 32'd2);
        serve(2'd0, 32'h0);
        chk("R10 order b", {29'b0, g_client}, 32'd5);
        serve(2'd0, 32'h0);
        chk("R10 order c", {29'b0, g_client}, 32'd6);
        @(negedge clk);
        stage(2, 32'hC000_0012, 32'h0);
        stage(7, 32'hC000_0017, 32'h0);
        commit();
        serve(2'd0, 32'h0);
        chk("R10 wrap first", {29'b0, g_client}, 32'd7);
        serve(2'd0, 32'h0);
        chk("R10 wrap second", {29'b0, g_client}, 32'd2);

        // R11: locked client keeps the engine across a yield
        do_reset();
        cfg_lock[3] = 1'b1;
        stage(3, 32'hC100_0030, 32'h0);
        stage(4, 32'hC100_0040, 32'h0);
        commit();
        serve(2'd2, 32'h0);
        chk("R11 locked first", {29'b0, g_client}, 32'd3);
        chk("R11 unlimited burst", {16'b0, g_burst}, 32'h0000_FFFF);
        chk("R11 no wb on yield", {31'b0, g_wb}, 32'h0);
        serve(2'd0, 32'h0);
        chk("R11 same client again", {29'b0, g_client}, 32'd3);
        serve(2'd0, 32'h0);
        chk("R11 other after", {29'b0, g_client}, 32'd4);
        cfg_lock = '0;

        // R12: unlocked client yields to the next in rotation
        do_reset();
        stage(3, 32'hC100_0030, 32'h0);
        stage(4, 32'hC100_0040, 32'h0);
        commit();
        serve(2'd2, 32'h0);
        chk("R12 first", {29'b0, g_client}, 32'd3);
        chk("R12 no wb on yield", {31'b0, g_wb}, 32'h0);
        chk("R12 still pending", {31'b0, mb0[3][31]}, 32'h1);
        serve(2'd0, 32'h0);
        chk("R12 next in rotation", {29'b0, g_client}, 32'd4);
        serve(2'd0, 32'h0);
        chk("R12 resumed", {29'b0, g_client}, 32'd3);
        @(negedge clk);
        chk("R12 resumed completes", mb0[3], 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule